// File: doc/BRIEF.md
# Quarter-Rate I/Q Down Converter

This block sits behind a multi-bit band-pass sigma-delta modulator whose wanted band is centred on one quarter of the sample rate. Each accepted modulator code is rotated to baseband by a local oscillator running at exactly fs/4. At that frequency the oscillator only ever takes the values +1, 0 and -1, so the mixer is a sign-and-zero selector and needs no multiplier. A two-bit phase counter drives it, producing an in-phase and a quadrature stream.

Each stream then passes through its own third-order cascaded integrator-comb decimator. The decimator lowers the word rate by a parameterised ratio and widens the word so that the full filter gain is kept without rounding. A constant input lands at fs/4 after mixing and falls in a filter null, so it settles to zero at the outputs. A tone at fs/4 comes out as a constant I/Q pair.

Top module: `ddc_quarter_rate`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: The mixer phase starts at 0 after reset and advances by one, modulo 4, only on cycles where `in_valid` is high. For the n-th accepted code x (n counted from 0), the I value is +x, 0, -x, 0 and the Q value is 0, -x, 0, +x for n mod 4 = 0, 1, 2, 3.
- R3: Let m count outputs from 0. Output m equals the sum over k of h[k]·v[n-k], where n = m·RATIO + RATIO - 1, v is the mixed I or Q stream, v at negative indices is 0, and h is three length-RATIO boxcars convolved with each other.
- R4: `out_valid` is a single-cycle pulse on the clock edge after every RATIO-th accepted code, and never at any other time. The first pulse follows the RATIO-th code after reset. `out_i` and `out_q` hold their values between pulses.
- R5: Outputs are IN_W + 3·log2(RATIO) bits wide, signed two's complement. They are exact for every sequence of input codes, including full-scale codes of either sign.
- R6: Cycles with `in_valid` low change neither the filter state nor the mixer phase. A stream with gaps gives the same outputs as the same codes sent back to back.
- R7: A constant input code gives `out_i` = 0 and `out_q` = 0 from the fourth output onward.
- R8: An input that repeats A, 0, -A, 0 (an fs/4 tone in phase) gives a constant `out_i` and `out_q` = 0 from the fourth output onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `in_code` for this cycle |
| in_code | input | IN_W | Signed modulator output code |
| out_valid | output | 1 | One-cycle strobe for a decimated I/Q pair |
| out_i | output | IN_W+3·log2(RATIO) | Signed in-phase output |
| out_q | output | IN_W+3·log2(RATIO) | Signed quadrature output |

## Verification
The bench builds the block with IN_W = 4 and RATIO = 8, which gives 13-bit outputs and a 22-tap filter. At this size every ordered pair of the 16 input codes can be sent, at both mixer phase parities. Full-scale extreme patterns can also be held long enough to reach the largest possible output magnitude. Every output is compared with a direct convolution against taps that the bench counts from the three boxcars, and the strobe is checked against the bench's own count of accepted codes on every cycle.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [1:0] {
    PH_COS_POS = 2'd0,
    PH_SIN_NEG = 2'd1,
    PH_COS_NEG = 2'd2,
    PH_SIN_POS = 2'd3
  } lo_phase_e;
endpackage

// File: rtl/ddc_lo_mixer.sv
module ddc_lo_mixer
  import ddc_pkg::*;
#(
  parameter int IN_W = 4,
  localparam int MW = IN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_code,
  output logic signed [MW-1:0] mix_i,
  output logic signed [MW-1:0] mix_q
);

  lo_phase_e phase_q, phase_d;
  logic signed [MW-1:0] pos_v, neg_v;

  always_comb begin
    phase_d = phase_q;
    if (in_valid) phase_d = lo_phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_COS_POS;
    else        phase_q <= phase_d;
  end

  always_comb begin
    pos_v = {in_code[IN_W-1], in_code};
    neg_v = -pos_v;
    mix_i = '0;
    mix_q = '0;
    unique case (phase_q)
      PH_COS_POS: mix_i = pos_v;
      PH_SIN_NEG: mix_q = neg_v;
      PH_COS_NEG: mix_i = neg_v;
      PH_SIN_POS: mix_q = pos_v;
    endcase
  end

  // R2: phase steps once per accepted code, holds otherwise
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phase_q == lo_phase_e'($past(phase_q) + 2'd1)));
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));

endmodule

// File: rtl/ddc_cic_decim.sv
module ddc_cic_decim #(
  parameter int IN_W   = 5,
  parameter int W      = 16,
  parameter int RATIO  = 16,
  parameter int STAGES = 3,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [IN_W-1:0]     in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  logic signed [W-1:0] integ_q [STAGES];
  logic signed [W-1:0] integ_d [STAGES];
  logic signed [W-1:0] dly_q   [STAGES];
  logic signed [W-1:0] comb_v  [STAGES+1];
  logic signed [W-1:0] ext_v;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                last_c, fire_c;
  logic                vld_q;
  logic signed [W-1:0] out_q;

  always_comb begin
    ext_v = W'($signed(in_data));
    integ_d[0] = integ_q[0] + ext_v;
    for (int s = 1; s < STAGES; s++) integ_d[s] = integ_q[s] + integ_d[s-1];
    last_c = (cnt_q == CNT_W'(RATIO - 1));
    fire_c = in_valid && last_c;
    cnt_d  = cnt_q;
    if (in_valid) cnt_d = last_c ? '0 : cnt_q + CNT_W'(1);
    comb_v[0] = integ_d[STAGES-1];
    for (int s = 0; s < STAGES; s++) comb_v[s+1] = comb_v[s] - dly_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end
      cnt_q <= '0;
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= fire_c;
      if (in_valid) begin
        cnt_q <= cnt_d;
        for (int s = 0; s < STAGES; s++) integ_q[s] <= integ_d[s];
      end
      if (fire_c) begin
        for (int s = 0; s < STAGES; s++) dly_q[s] <= comb_v[s];
        out_q <= comb_v[STAGES];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = out_q;

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RATIO - 1));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_c |=> $stable(out_data));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(integ_q[STAGES-1]) && $stable(cnt_q)));

endmodule

// File: rtl/ddc_quarter_rate.sv
module ddc_quarter_rate #(
  parameter int IN_W  = 4,
  parameter int RATIO = 16,
  localparam int STAGES = 3,
  localparam int OUT_W  = IN_W + STAGES * $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_code,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);

  localparam int MW = IN_W + 1;

  logic signed [MW-1:0]    mix_i, mix_q;
  logic                    vld_i, vld_q;
  logic signed [OUT_W-1:0] dat_i, dat_q;

  ddc_lo_mixer #(.IN_W(IN_W)) u_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .mix_i(mix_i), .mix_q(mix_q)
  );

  ddc_cic_decim #(.IN_W(MW), .W(OUT_W), .RATIO(RATIO), .STAGES(STAGES)) u_cic_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(mix_i),
    .out_valid(vld_i), .out_data(dat_i)
  );

  ddc_cic_decim #(.IN_W(MW), .W(OUT_W), .RATIO(RATIO), .STAGES(STAGES)) u_cic_q (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(mix_q),
    .out_valid(vld_q), .out_data(dat_q)
  );

  assign out_valid = vld_i;
  assign out_i     = dat_i;
  assign out_q     = dat_q;

  assert_branch_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i == vld_q);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_i == '0 && out_q == '0));

endmodule

// File: tb/test_ddc_quarter_rate.sv
module test_ddc_quarter_rate;
  localparam int IN_W  = 4;
  localparam int RATIO = 8;
  localparam int OUT_W = IN_W + 3 * $clog2(RATIO);
  localparam int NTAP  = 3 * RATIO - 2;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [IN_W-1:0]  in_code = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_i, out_q;

  int total = 0, bad = 0;
  int h [NTAP];
  int xs [8192];
  int acc, nout, mode, last_i;
  bit prevv;

  always #5 clk = ~clk;

  ddc_quarter_rate #(.IN_W(IN_W), .RATIO(RATIO)) i_ddc_quarter_rate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int mi(int n);
    if (n < 0) return 0;
    case (n % 4)
      0: return xs[n];
      2: return -xs[n];
      default: return 0;
    endcase
  endfunction

  function automatic int mq(int n);
    if (n < 0) return 0;
    case (n % 4)
      1: return -xs[n];
      3: return xs[n];
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: samples away from the rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 valid", int'(out_valid), 0);
      check("R1 i", int'($signed(out_i)), 0);
      check("R1 q", int'($signed(out_q)), 0);
      acc = 0; nout = 0; prevv = 0;
    end else begin
      // R4: strobe exactly after every RATIO-th accepted code
      check("R4 strobe", int'(out_valid), int'(prevv && acc > 0 && (acc % RATIO) == 0));
      if (out_valid) begin
        int n, ei, eq;
        n = nout * RATIO + RATIO - 1;
        ei = 0; eq = 0;
        for (int k = 0; k < NTAP; k++) begin
          ei += h[k] * mi(n - k);
          eq += h[k] * mq(n - k);
        end
        // R3 (and R5/R6 depending on stimulus): exact filtered value
        check(mode == 5 ? "R5 i" : mode == 6 ? "R6 i" : "R3 i", int'($signed(out_i)), ei);
        check(mode == 5 ? "R5 q" : mode == 6 ? "R6 q" : "R3 q", int'($signed(out_q)), eq);
        if (mode == 7 && nout >= 3) begin
          check("R7 dc i", int'($signed(out_i)), 0);
          check("R7 dc q", int'($signed(out_q)), 0);
        end
        if (mode == 8 && nout >= 4) check("R8 tone i const", int'($signed(out_i)), last_i);
        if (mode == 8 && nout >= 3) check("R8 tone q", int'($signed(out_q)), 0);
        last_i = int'($signed(out_i));
        nout++;
      end else if (nout > 0) begin
        check("R4 hold", int'($signed(out_i)), last_i);
      end
      prevv = in_valid;
      if (in_valid) begin
        xs[acc] = int'($signed(in_code));
        acc++;
      end
    end
  end

  task automatic send(int c, bit v);
    @(posedge clk); #2;
    in_valid = v;
    in_code  = IN_W'(c);
  endtask

  task automatic do_reset(int m);
    @(posedge clk); #2;
    rst_n = 0; in_valid = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    mode = m;
  endtask

  task automatic flush();
    repeat (4) send(0, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode = 3; last_i = 0;
    // taps: count ways three boxcar offsets sum to k
    for (int k = 0; k < NTAP; k++) h[k] = 0;
    for (int a = 0; a < RATIO; a++)
      for (int b = 0; b < RATIO; b++)
        for (int c = 0; c < RATIO; c++) h[a + b + c]++;

    // R1/R2/R3: all ordered code pairs, both phase parities
    do_reset(3);
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        send(a, 1);
        send(b, 1);
      end
    send(1, 1);
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        send(a, 1);
        send(b, 1);
      end
    flush();

    // R6: pseudo-random codes with idle gaps
    do_reset(6);
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 800; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[6:5] == 2'b00) send(0, 0);
        send(int'($signed(lf[3:0])), 1);
      end
    end
    flush();

    // R5: full-scale extremes driving I and Q to maximum magnitude
    do_reset(5);
    for (int i = 0; i < 24; i++) begin send(7, 1); send(7, 1); send(-8, 1); send(-8, 1); end
    for (int i = 0; i < 24; i++) begin send(-8, 1); send(-8, 1); send(7, 1); send(7, 1); end
    for (int i = 0; i < 24; i++) begin send(-8, 1); send(-8, 1); send(-8, 1); send(-8, 1); end
    flush();

    // R7: constant inputs settle to zero
    for (int c = -8; c < 8; c += 5) begin
      do_reset(7);
      for (int i = 0; i < 6 * RATIO; i++) send(c, 1);
      flush();
    end

    // R8: in-phase fs/4 tone gives constant I, zero Q
    for (int a = -8; a < 8; a += 7) begin
      do_reset(8);
      for (int i = 0; i < 2 * RATIO; i++) begin
        send(a, 1); send(0, 1); send(a == -8 ? 7 : -a, 1); send(0, 1);
      end
      flush();
    end

    // R1: reset mid-stream clears everything
    send(5, 1); send(3, 1);
    do_reset(3);
    send(0, 0);
    repeat (3) @(negedge clk);
    check("R1 post reset i", int'($signed(out_i)), 0);
    check("R1 post reset valid", int'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule